// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data memory addresses from a small bank of pointer register sets. Each set holds a pointer, a signed step and a buffer size. When a set is used for a memory access, the block presents the pointer as the address. It then advances the pointer by the step. If the buffer size is nonzero, the advance stays inside a window of that many words. If the size is zero, the pointer moves linearly. A step-only command advances the pointer in the same way but raises no memory request. Software uses this to skip ahead or back in a delay line.

The window starts at the pointer value written most recently. Each pointer write also loads a hidden base register, and the wrap is computed against that base. A negative step that falls below the base comes back in from the top of the window. A buffer size equal to the total of two adjacent buffers lets the pointer sweep through both before it wraps. The address and request come out of registers one clock after the command.

Top module: `cbuf_agen`

## Requirements
- R1: After reset, `mem_req` is low and every set's pointer, step, size and base are zero, so an access on any set gives address 0.
- R2: A register write with `wr_kind` = 0 loads the pointer of set `wr_sel` from `wr_data[13:0]` and also loads that set's base. `wr_kind` = 1 loads the step as a 14-bit two's-complement value from `wr_data[13:0]`. `wr_kind` = 2 loads the 15-bit size from `wr_data[14:0]`.
- R3: A command with `op_valid` = 1 and `op_kind` = 0 (access) raises `mem_req` on the next clock, with `mem_addr` equal to the pointer before that command. When there is no access, `mem_req` is low on the next clock.
- R4: With size 0, each command sets pointer = (pointer + step) mod 16384.
- R5: With nonzero size L and a step of magnitude below L, a sum at or above base+L has L subtracted from it.
- R6: With a negative step, a sum below the base has L added to it.
- R7: A command with `op_kind` = 1 (step-only) advances the pointer exactly as an access would, and `mem_req` stays low on the next clock.
- R8: Commands and writes on one set leave the other sets unchanged.
- R9: When a pointer write and a command hit the same set in the same cycle, the written value wins. A write to the step or the size in the same cycle does not affect that command, which uses the old values.
- R10: A size equal to the total of two adjacent buffers makes the pointer sweep both buffers before it returns to the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Set written |
| wr_kind | input | 2 | 0 pointer, 1 step, 2 size |
| wr_data | input | 15 | Write value |
| op_valid | input | 1 | Command strobe |
| op_kind | input | 1 | 0 access, 1 step-only |
| op_sel | input | 2 | Set used by the command |
| mem_req | output | 1 | Memory request, one clock after an access |
| mem_addr | output | 14 | Address of the request |

## Verification
If a pointer holds the wrong value, the error shows at `mem_addr` on the next access to that set. This holds even when the fault came in through a step-only command or a wrap. The reference model is compared on every clock, so a wrong wrap shows up one clock after the first access that follows the faulty advance. Long runs with small windows and negative steps make sure both wrap directions are crossed many times. A wrong request flag shows in the very next cycle.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;
  typedef enum logic [1:0] {
    FLD_PTR  = 2'd0,
    FLD_STEP = 2'd1,
    FLD_SIZE = 2'd2
  } fld_e;

  typedef enum logic {
    CMD_ACCESS  = 1'b0,
    CMD_STEPONLY = 1'b1
  } cmd_e;
endpackage

// File: rtl/cbuf_agen_wrap.sv
module cbuf_agen_wrap #(
  parameter int AW = 14,
  parameter int LW = AW + 1
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [LW-1:0] size,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 3;

  logic signed [XW-1:0] sum, lo, hi, sz;

  always_comb begin
    sum = $signed({3'b000, ptr}) + $signed({{3{step[AW-1]}}, step});
    lo  = $signed({3'b000, base});
    sz  = $signed({{(XW-LW){1'b0}}, size});
    hi  = lo + sz;
    if (size == '0)
      nxt = sum[AW-1:0];
    else if (sum >= hi)
      nxt = AW'(sum - sz);
    else if (sum < lo)
      nxt = AW'(sum + sz);
    else
      nxt = sum[AW-1:0];
  end
endmodule

// File: rtl/cbuf_agen_regs.sv
module cbuf_agen_regs
  import cbuf_agen_pkg::*;
#(
  parameter int NSETS = 4,
  parameter int AW    = 14,
  parameter int LW    = AW + 1,
  localparam int SW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [1:0]    wr_kind,
  input  logic [LW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [AW-1:0] upd_ptr,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] cur_base,
  output logic [AW-1:0] cur_step,
  output logic [LW-1:0] cur_size
);
  logic [AW-1:0] ptr_q  [NSETS];
  logic [AW-1:0] base_q [NSETS];
  logic [AW-1:0] step_q [NSETS];
  logic [LW-1:0] size_q [NSETS];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic          hit_w, ptr_w, step_w, size_w, ptr_u, ptr_en;
    logic [AW-1:0] ptr_d;

    always_comb begin
      hit_w  = wr_en && (wr_sel == SW'(s));
      ptr_w  = hit_w && (fld_e'(wr_kind) == FLD_PTR);
      step_w = hit_w && (fld_e'(wr_kind) == FLD_STEP);
      size_w = hit_w && (fld_e'(wr_kind) == FLD_SIZE);
      ptr_u  = upd_en && (upd_sel == SW'(s));
      ptr_en = ptr_w || ptr_u;
      ptr_d  = ptr_w ? wr_data[AW-1:0] : upd_ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[s]  <= '0;
        base_q[s] <= '0;
        step_q[s] <= '0;
        size_q[s] <= '0;
      end else begin
        if (ptr_en) ptr_q[s]  <= ptr_d;
        if (ptr_w)  base_q[s] <= wr_data[AW-1:0];
        if (step_w) step_q[s] <= wr_data[AW-1:0];
        if (size_w) size_q[s] <= wr_data;
      end
    end
  end

  always_comb begin
    cur_ptr  = ptr_q[upd_sel];
    cur_base = base_q[upd_sel];
    cur_step = step_q[upd_sel];
    cur_size = size_q[upd_sel];
  end
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
  import cbuf_agen_pkg::*;
#(
  parameter int NSETS = 4,
  parameter int AW    = 14,
  localparam int LW   = AW + 1,
  localparam int SW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [1:0]    wr_kind,
  input  logic [LW-1:0] wr_data,
  input  logic          op_valid,
  input  logic          op_kind,
  input  logic [SW-1:0] op_sel,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  logic [AW-1:0] cur_ptr, cur_base, cur_step, nxt_ptr;
  logic [LW-1:0] cur_size;
  logic          req_d, addr_en;
  logic [AW-1:0] addr_d;

  cbuf_agen_regs #(.NSETS(NSETS), .AW(AW), .LW(LW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_kind  (wr_kind),
    .wr_data  (wr_data),
    .upd_en   (op_valid),
    .upd_sel  (op_sel),
    .upd_ptr  (nxt_ptr),
    .cur_ptr  (cur_ptr),
    .cur_base (cur_base),
    .cur_step (cur_step),
    .cur_size (cur_size)
  );

  cbuf_agen_wrap #(.AW(AW), .LW(LW)) u_wrap (
    .ptr  (cur_ptr),
    .base (cur_base),
    .step (cur_step),
    .size (cur_size),
    .nxt  (nxt_ptr)
  );

  always_comb begin
    req_d   = op_valid && (cmd_e'(op_kind) == CMD_ACCESS);
    addr_en = req_d;
    addr_d  = cur_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_req <= req_d;
      if (addr_en) mem_addr <= addr_d;
    end
  end
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
  parameter int AW = 14,
  parameter int LW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_kind,
  input logic          mem_req,
  input logic [AW-1:0] cur_ptr,
  input logic [AW-1:0] cur_base,
  input logic [AW-1:0] cur_step,
  input logic [LW-1:0] cur_size,
  input logic [AW-1:0] nxt_ptr
);
  logic [LW:0]   win_end;
  logic [AW-1:0] step_mag;
  logic          in_win, nxt_in_win, small_step;

  always_comb begin
    win_end    = {2'b00, cur_base} + {1'b0, cur_size};
    step_mag   = cur_step[AW-1] ? (~cur_step + 1'b1) : cur_step;
    small_step = {1'b0, step_mag} < cur_size;
    in_win     = (cur_ptr >= cur_base) && ({2'b00, cur_ptr} < win_end);
    nxt_in_win = (nxt_ptr >= cur_base) && ({2'b00, nxt_ptr} < win_end);
  end

  a_r3_access_req: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_kind) |=> mem_req);
  a_r3_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !mem_req);
  a_r7_steponly_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind) |=> !mem_req);
  a_r5_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cur_size != '0 && small_step && in_win) |-> nxt_in_win);
endmodule

bind cbuf_agen cbuf_agen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_kind  (op_kind),
  .mem_req  (mem_req),
  .cur_ptr  (cur_ptr),
  .cur_base (cur_base),
  .cur_step (cur_step),
  .cur_size (cur_size),
  .nxt_ptr  (nxt_ptr)
);

// File: tb/sim_cbuf_agen.sv
`timescale 1ns/1ps
module sim_cbuf_agen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, op_valid, op_kind;
  logic [1:0]  wr_sel, wr_kind, op_sel;
  logic [14:0] wr_data;
  logic        mem_req;
  logic [13:0] mem_addr;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int m_ptr[4], m_base[4], m_step[4], m_size[4];

  always #2.5 clk = ~clk;

  cbuf_agen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_kind(wr_kind), .wr_data(wr_data), .op_valid(op_valid),
    .op_kind(op_kind), .op_sel(op_sel), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sx14(input int v);
    int t = v & 16383;
    return (t >= 8192) ? t - 16384 : t;
  endfunction

  task automatic step(input bit we, input int ws, input int wk, input int wd,
                      input bit ov, input bit ok, input int os);
    bit e_req = 0;
    int e_addr = 0, nx;
    @(negedge clk);
    wr_en = we; wr_sel = 2'(ws); wr_kind = 2'(wk); wr_data = 15'(wd);
    op_valid = ov; op_kind = ok; op_sel = 2'(os);
    if (ov) begin
      e_req = !ok;
      e_addr = m_ptr[os];
      nx = m_ptr[os] + m_step[os];
      if (m_size[os] == 0) nx = nx & 16383;
      else if (nx >= m_base[os] + m_size[os]) nx = nx - m_size[os];
      else if (nx < m_base[os]) nx = nx + m_size[os];
      m_ptr[os] = nx;
    end
    if (we) begin
      case (wk)
        0: begin m_ptr[ws] = wd & 16383; m_base[ws] = wd & 16383; end
        1: m_step[ws] = sx14(wd);
        2: m_size[ws] = wd & 32767;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    check("mem_req", int'(mem_req), int'(e_req));
    if (e_req) check("mem_addr", int'(mem_addr), e_addr);
  endtask

  task automatic wr(input int s, input int k, input int d);
    step(1, s, k, d, 0, 0, 0);
  endtask

  task automatic acc(input int s, input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, s);
  endtask

  task automatic setup(input int s, input int p, input int st, input int sz);
    wr(s, 1, st & 16383);
    wr(s, 2, sz);
    wr(s, 0, p);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_kind = 0; wr_data = 0;
    op_valid = 0; op_kind = 0; op_sel = 0;
    for (int s = 0; s < 4; s++) begin m_ptr[s] = 0; m_base[s] = 0; m_step[s] = 0; m_size[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; check("mem_req after reset", int'(mem_req), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    for (int s = 0; s < 4; s++) acc(s, 2);

    tag = "R2"; setup(1, 100, 3, 0); acc(1, 2);
    tag = "R4"; acc(1, 5);
    setup(2, 16380, 5, 0); acc(2, 4);
    setup(2, 3, -7, 0); acc(2, 3);
    tag = "R5"; setup(0, 200, 3, 10); acc(0, 12);
    tag = "R6"; setup(3, 500, -1, 7); acc(3, 10);
    setup(3, 500, -3, 7); acc(3, 9);
    tag = "R7";
    step(0, 0, 0, 0, 1, 1, 0); step(0, 0, 0, 0, 1, 1, 0);
    acc(0, 2);
    step(0, 0, 0, 0, 1, 1, 3); acc(3, 1);
    tag = "R8";
    for (int i = 0; i < 6; i++) begin acc(i % 4, 1); step(0, 0, 0, 0, 1, 1, (i + 1) % 4); end
    acc(1, 1); acc(2, 1);
    tag = "R9";
    step(1, 1, 0, 777, 1, 0, 1); acc(1, 2);
    step(1, 0, 1, 5, 1, 0, 0); acc(0, 2);
    step(1, 3, 2, 4, 1, 0, 3); acc(3, 3);
    tag = "R10"; setup(2, 1000, 1, 20); acc(2, 25);
    setup(2, 1000, -2, 20); acc(2, 25);
    tag = "R3";
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, (i % 3) != 0, (i % 5) == 0, i % 4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule